// File: doc/BRIEF.md
# Interleaved Memory Block-Fill Controller

This block sits between a cache and a main memory built as four word-interleaved banks. When the cache asks for a 32-byte block, the controller reads the block's eight 32-bit words from the banks in two overlapped rounds. In each round all four banks work at once. The words are collected into a block buffer, streamed back one per cycle in ascending order, and the whole block is presented on a wide output in the cycle the last word appears.

Single-word writes go to the one bank that owns the word. Each bank is a synchronous memory with a fixed access latency set by a parameter. A bank takes a new access only when it has none outstanding. Writes win over fills: a fill is accepted only when no bank is busy and no write is being requested.

Top module: `bank_fill_ctrl`

## Requirements
- R1: After reset, fillReady is 1, and wrBusy, wordValid and fillDone are 0.
- R2: A word at word address a is held in bank a mod 4 (the two low address bits) at bank location a div 4. A fill of block b returns the words at word addresses 8b to 8b+7.
- R3: Each accepted fill produces exactly eight wordValid cycles. Their wordIdx values run 0 to 7 in order, and wordData equals the last value written to word address 8b+wordIdx. wordValid never rises while fillReady is 1.
- R4: Let cycle 0 be the first cycle after the accepting edge and L the bank latency. Word k (k < 4) is valid in cycle L+1+k. Word k (k >= 4) is valid in cycle (k-4)+max(L+5, 2L+2). wordValid is 0 in every other cycle.
- R5: fillDone is 1 only in the cycle that word 7 is valid. In that cycle blockData holds word k in bits [32k+31:32k] for all eight words.
- R6: wrBusy is 1 while a fill is in progress, from the first cycle after the accepting edge through the fillDone cycle. It is also 1 for L cycles after a write to the same bank (bank = wrAddr mod 4) is accepted. A write is accepted on an edge where wrReq is 1 and wrBusy is 0. Two writes to one bank are accepted L+1 cycles apart.
- R7: fillReady is 1 only when no fill is in progress, no bank access is outstanding and wrReq is 0. A fill is accepted on an edge where fillReq and fillReady are both 1, and fillReady is 0 in the next cycle. fillReq has no effect while fillReady is 0.
- R8: Writes to different banks can be accepted on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fillReq | input | 1 | Block fill request |
| fillAddr | input | 5 | Block address (word address div 8) |
| fillReady | output | 1 | A fill can be accepted this cycle |
| wrReq | input | 1 | Single-word write request |
| wrAddr | input | 8 | Word address of the write |
| wrData | input | 32 | Write data |
| wrBusy | output | 1 | The write cannot be accepted this cycle |
| wordValid | output | 1 | A fill word is on wordData |
| wordIdx | output | 3 | Position of that word in its block |
| wordData | output | 32 | Fill word data |
| fillDone | output | 1 | Last word of the block is valid |
| blockData | output | 256 | Assembled block, word k at bits [32k+31:32k] |

## Verification
The assertions assume that the requester holds fillReq, wrReq and wrAddr steady until its request is taken. They also assume no fill is issued for a block whose words were never written. The bench drives every request through tasks that wait on wrBusy or fillReady before releasing it, and it only fills blocks it has written in full. A cycle-accurate model in the bench tracks when each bank and the fill sequence become free. That model predicts wrBusy, fillReady and the timing of every word, including the gap before the second round at the default latency.

// File: rtl/bank_fill_pkg.sv
package bank_fill_pkg;

  localparam int RND_W_MAX = 4;

  typedef enum logic {ST_IDLE, ST_FILL} fill_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic                 clear;
    logic                 issue;
    logic [RND_W_MAX-1:0] issueRnd;
    logic                 capture;
    logic [RND_W_MAX-1:0] capRnd;
    logic                 emit;
    logic                 wrStart;
  } fill_strobe_t;

  // status from datapath to control
  typedef struct packed {
    logic dataValid;
    logic allIdle;
    logic wrBankBusy;
    logic wordAvail;
    logic lastWord;
  } fill_status_t;

endpackage

// File: rtl/bank_fill_bank.sv
module bank_fill_bank #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  parameter int LAT    = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     start,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] addr,
  input  logic [DATA_W-1:0]        wdata,
  output logic                     busy,
  output logic                     rValid,
  output logic [DATA_W-1:0]        rData
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(LAT + 1);

  logic [CW-1:0]     cnt;
  logic              pendWe;
  logic [AW-1:0]     pendAddr;
  logic [DATA_W-1:0] pendData;
  logic [DATA_W-1:0] mem [DEPTH];

  assign busy = (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt      <= '0;
      pendWe   <= 1'b0;
      pendAddr <= '0;
      pendData <= '0;
      rValid   <= 1'b0;
    end else begin
      rValid <= 1'b0;
      if (start) begin
        cnt      <= CW'(LAT);
        pendWe   <= we;
        pendAddr <= addr;
        pendData <= wdata;
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
      if (cnt == CW'(1) && !pendWe) rValid <= 1'b1;
    end
  end

  // storage array, completes the access on the last latency cycle
  always_ff @(posedge clk) begin
    if (cnt == CW'(1)) begin
      if (pendWe) mem[pendAddr] <= pendData;
      else        rData         <= mem[pendAddr];
    end
  end
endmodule

// File: rtl/bank_fill_dp.sv
module bank_fill_dp
  import bank_fill_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int WORDS      = 8,
  parameter int BANKS      = 4,
  parameter int BANK_DEPTH = 64,
  parameter int LAT        = 4
) (
  input  logic                                        clk,
  input  logic                                        rstN,
  input  fill_strobe_t                                stb,
  input  logic [$clog2(BANKS*BANK_DEPTH)-$clog2(WORDS)-1:0] fillAddr,
  input  logic [$clog2(BANKS*BANK_DEPTH)-1:0]         wrAddr,
  input  logic [DATA_W-1:0]                           wrData,
  output fill_status_t                                sts,
  output logic [DATA_W-1:0]                           wordData,
  output logic [$clog2(WORDS)-1:0]                    wordIdx,
  output logic [WORDS*DATA_W-1:0]                     blockData
);
  localparam int BSEL_W  = $clog2(BANKS);
  localparam int INNER_W = $clog2(BANK_DEPTH);
  localparam int WADDR_W = BSEL_W + INNER_W;
  localparam int IDX_W   = $clog2(WORDS);
  localparam int BLK_W   = WADDR_W - IDX_W;
  localparam int ROUNDS  = WORDS / BANKS;

  logic [BLK_W-1:0]   blkReg;
  logic [BLK_W-1:0]   blkSel;
  logic [INNER_W-1:0] rdInner;
  logic [INNER_W-1:0] wrInner;
  logic [BSEL_W-1:0]  wrBank;

  logic [BANKS-1:0]  bankBusy;
  logic [BANKS-1:0]  bankValid;
  logic [DATA_W-1:0] bankData [BANKS];

  logic [WORDS-1:0][DATA_W-1:0] blkBuf;
  logic [WORDS-1:0]             have;
  logic [IDX_W-1:0]             outIdx;

  assign blkSel  = stb.clear ? fillAddr : blkReg;
  assign rdInner = INNER_W'(blkSel) * INNER_W'(ROUNDS) + INNER_W'(stb.issueRnd);
  assign wrBank  = wrAddr[BSEL_W-1:0];
  assign wrInner = wrAddr[WADDR_W-1:BSEL_W];

  for (genvar k = 0; k < BANKS; k++) begin : g_bank
    logic bankStart;
    logic [INNER_W-1:0] bankAddr;
    assign bankStart = stb.issue || (stb.wrStart && wrBank == BSEL_W'(k));
    assign bankAddr  = stb.issue ? rdInner : wrInner;

    bank_fill_bank #(
      .DATA_W(DATA_W), .DEPTH(BANK_DEPTH), .LAT(LAT)
    ) bank_i (
      .clk    (clk),
      .rstN   (rstN),
      .start  (bankStart),
      .we     (!stb.issue),
      .addr   (bankAddr),
      .wdata  (wrData),
      .busy   (bankBusy[k]),
      .rValid (bankValid[k]),
      .rData  (bankData[k])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      blkReg <= '0;
      blkBuf <= '0;
      have   <= '0;
      outIdx <= '0;
    end else begin
      if (stb.clear) begin
        blkReg <= fillAddr;
        have   <= '0;
        outIdx <= '0;
      end else begin
        if (stb.emit) outIdx <= outIdx + 1'b1;
        if (stb.capture) begin
          for (int i = 0; i < WORDS; i++) begin
            if (stb.capRnd == RND_W_MAX'(i / BANKS)) begin
              blkBuf[i] <= bankData[i % BANKS];
              have[i]   <= 1'b1;
            end
          end
        end
      end
    end
  end

  assign sts.dataValid  = &bankValid;
  assign sts.allIdle    = ~|bankBusy;
  assign sts.wrBankBusy = bankBusy[wrBank];
  assign sts.wordAvail  = have[outIdx];
  assign sts.lastWord   = (outIdx == IDX_W'(WORDS - 1));

  assign wordData  = blkBuf[outIdx];
  assign wordIdx   = outIdx;
  assign blockData = blkBuf;
endmodule

// File: rtl/bank_fill_ctl.sv
module bank_fill_ctl
  import bank_fill_pkg::*;
#(
  parameter int ROUNDS = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         fillReq,
  input  logic         wrReq,
  input  fill_status_t sts,
  output fill_strobe_t stb,
  output logic         fillReady,
  output logic         wrBusy,
  output logic         wordValid,
  output logic         fillDone
);
  fill_state_t          state;
  logic [RND_W_MAX-1:0] capRnd;
  logic                 idle;

  assign idle = (state == ST_IDLE);

  always_comb begin
    stb       = '0;
    fillReady = idle && sts.allIdle && !wrReq;
    wrBusy    = !idle || sts.wrBankBusy;
    stb.wrStart = wrReq && !wrBusy;
    if (idle) begin
      stb.clear    = fillReady && fillReq;
      stb.issue    = stb.clear;
      stb.issueRnd = '0;
    end else begin
      stb.capture  = sts.dataValid;
      stb.capRnd   = capRnd;
      stb.issue    = sts.dataValid && (capRnd != RND_W_MAX'(ROUNDS - 1));
      stb.issueRnd = RND_W_MAX'(capRnd + 1'b1);
      stb.emit     = sts.wordAvail;
    end
  end

  assign wordValid = stb.emit;
  assign fillDone  = stb.emit && sts.lastWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      capRnd <= '0;
    end else begin
      case (state)
        ST_IDLE: if (stb.clear) begin
          state  <= ST_FILL;
          capRnd <= '0;
        end
        default: begin
          if (stb.capture) capRnd <= capRnd + 1'b1;
          if (fillDone) state <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/bank_fill_ctrl.sv
module bank_fill_ctrl
  import bank_fill_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int WORDS      = 8,
  parameter int BANKS      = 4,
  parameter int BANK_DEPTH = 64,
  parameter int LAT        = 4,
  localparam int WADDR_W   = $clog2(BANKS * BANK_DEPTH),
  localparam int IDX_W     = $clog2(WORDS),
  localparam int BLK_W     = WADDR_W - IDX_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    fillReq,
  input  logic [BLK_W-1:0]        fillAddr,
  output logic                    fillReady,
  input  logic                    wrReq,
  input  logic [WADDR_W-1:0]      wrAddr,
  input  logic [DATA_W-1:0]       wrData,
  output logic                    wrBusy,
  output logic                    wordValid,
  output logic [IDX_W-1:0]        wordIdx,
  output logic [DATA_W-1:0]       wordData,
  output logic                    fillDone,
  output logic [WORDS*DATA_W-1:0] blockData
);
  fill_strobe_t stb;
  fill_status_t sts;

  bank_fill_ctl #(.ROUNDS(WORDS / BANKS)) ctl_i (
    .clk       (clk),
    .rstN      (rstN),
    .fillReq   (fillReq),
    .wrReq     (wrReq),
    .sts       (sts),
    .stb       (stb),
    .fillReady (fillReady),
    .wrBusy    (wrBusy),
    .wordValid (wordValid),
    .fillDone  (fillDone)
  );

  bank_fill_dp #(
    .DATA_W(DATA_W), .WORDS(WORDS), .BANKS(BANKS),
    .BANK_DEPTH(BANK_DEPTH), .LAT(LAT)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .fillAddr  (fillAddr),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .sts       (sts),
    .wordData  (wordData),
    .wordIdx   (wordIdx),
    .blockData (blockData)
  );
endmodule

// File: rtl/bank_fill_chk.sv
module bank_fill_chk #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             fillReq,
  input logic             fillReady,
  input logic             wrReq,
  input logic             wrBusy,
  input logic             wordValid,
  input logic [IDX_W-1:0] wordIdx,
  input logic             fillDone
);
  logic [IDX_W-1:0] expIdx;

  always_ff @(posedge clk) begin
    if (!rstN)          expIdx <= '0;
    else if (wordValid) expIdx <= expIdx + 1'b1;
  end

  assert_word_order_R3: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> wordIdx == expIdx);

  assert_no_word_when_ready_R3: assert property (@(posedge clk) disable iff (!rstN)
    fillReady |-> !wordValid);

  assert_done_on_last_R5: assert property (@(posedge clk) disable iff (!rstN)
    fillDone |-> (wordValid && wordIdx == {IDX_W{1'b1}}));

  assert_write_held_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> wrBusy);

  assert_write_blocks_fill_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && !wrBusy) |=> !fillReady);

  assert_accept_closes_R7: assert property (@(posedge clk) disable iff (!rstN)
    (fillReq && fillReady) |=> !fillReady);
endmodule

bind bank_fill_ctrl bank_fill_chk #(.IDX_W(IDX_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .fillReq   (fillReq),
  .fillReady (fillReady),
  .wrReq     (wrReq),
  .wrBusy    (wrBusy),
  .wordValid (wordValid),
  .wordIdx   (wordIdx),
  .fillDone  (fillDone)
);

// File: tb/bank_fill_ctrl_tb_top.sv
module bank_fill_ctrl_tb_top;
  localparam int L = 4;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         fillReq = 1'b0;
  logic [4:0]   fillAddr = '0;
  logic         fillReady;
  logic         wrReq = 1'b0;
  logic [7:0]   wrAddr = '0;
  logic [31:0]  wrData = '0;
  logic         wrBusy;
  logic         wordValid;
  logic [2:0]   wordIdx;
  logic [31:0]  wordData;
  logic         fillDone;
  logic [255:0] blockData;

  always #5 clk = ~clk;

  bank_fill_ctrl #(.LAT(L)) dut_i (
    .clk(clk), .rstN(rstN), .fillReq(fillReq), .fillAddr(fillAddr),
    .fillReady(fillReady), .wrReq(wrReq), .wrAddr(wrAddr), .wrData(wrData),
    .wrBusy(wrBusy), .wordValid(wordValid), .wordIdx(wordIdx),
    .wordData(wordData), .fillDone(fillDone), .blockData(blockData)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // reference model state
  logic [31:0]  refMem [256];
  int           busyUntil [4];
  int           fillStart = 0;
  int           fillEnd = 0;
  int           qAt[$];
  int           qIdx[$];
  logic [31:0]  qData[$];
  logic [255:0] expBlk;
  int           lastAcc = 0;

  task automatic chk(input bit ok, input string tag, input logic [255:0] act,
                     input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int wordOffset(input int k);
    int late;
    late = (L + 5 > 2 * L + 2) ? L + 5 : 2 * L + 2;
    return (k < 4) ? (L + 1 + k) : ((k - 4) + late);
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN) begin
      bit expValid;
      bit fillAct;
      bit banksFree;
      expValid = (qAt.size() > 0) && (qAt[0] == cyc);
      chk(wordValid == expValid, "R4 wordValid timing", wordValid, expValid);
      if (expValid) begin
        chk(wordIdx == qIdx[0][2:0], "R3 wordIdx order", wordIdx, qIdx[0]);
        chk(wordData == qData[0], "R2 wordData bank mapping", wordData, qData[0]);
        chk(fillDone == (qIdx[0] == 7), "R5 fillDone on word 7", fillDone, qIdx[0] == 7);
        if (qIdx[0] == 7)
          chk(blockData == expBlk, "R5 blockData", blockData, expBlk);
        void'(qAt.pop_front());
        void'(qIdx.pop_front());
        void'(qData.pop_front());
      end else begin
        chk(fillDone == 1'b0, "R5 fillDone idle", fillDone, 0);
      end
      fillAct = (cyc >= fillStart) && (cyc < fillEnd);
      banksFree = 1'b1;
      for (int b = 0; b < 4; b++) if (cyc < busyUntil[b]) banksFree = 1'b0;
      chk(wrBusy == (fillAct || cyc < busyUntil[wrAddr % 4]), "R6 wrBusy",
          wrBusy, fillAct || cyc < busyUntil[wrAddr % 4]);
      chk(fillReady == (!fillAct && banksFree && !wrReq), "R7 fillReady",
          fillReady, !fillAct && banksFree && !wrReq);
      // model updates from the accepted requests
      if (wrReq && !wrBusy) begin
        refMem[wrAddr] = wrData;
        busyUntil[wrAddr % 4] = cyc + 1 + L;
      end
      if (fillReq && fillReady) begin
        int t0;
        t0 = cyc + 1;
        for (int k = 0; k < 8; k++) begin
          qAt.push_back(t0 + wordOffset(k));
          qIdx.push_back(k);
          qData.push_back(refMem[fillAddr * 8 + k]);
          expBlk[32*k +: 32] = refMem[fillAddr * 8 + k];
        end
        fillStart = t0;
        fillEnd = t0 + wordOffset(7) + 1;
        for (int b = 0; b < 4; b++) busyUntil[b] = t0 + 2 * L + 1;
      end
    end
  end

  task automatic doWrite(input int a, input logic [31:0] d);
    wrAddr = 8'(a);
    wrData = d;
    wrReq = 1'b1;
    do @(negedge clk); while (wrBusy);
    lastAcc = cyc;
    @(posedge clk);
    #1 wrReq = 1'b0;
  endtask

  task automatic doFill(input int b);
    fillAddr = 5'(b);
    fillReq = 1'b1;
    do @(negedge clk); while (!fillReady);
    @(posedge clk);
    #1 fillReq = 1'b0;
  endtask

  task automatic waitDone();
    do @(negedge clk); while (!fillDone);
    @(posedge clk);
    #1;
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired (R3)");
    finishRun();
  end

  initial begin
    int acc1;
    for (int b = 0; b < 4; b++) busyUntil[b] = 0;
    for (int i = 0; i < 256; i++) refMem[i] = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(fillReady == 1'b1, "R1 fillReady", fillReady, 1);
    chk(wrBusy == 1'b0, "R1 wrBusy", wrBusy, 0);
    chk(wordValid == 1'b0, "R1 wordValid", wordValid, 0);
    chk(fillDone == 1'b0, "R1 fillDone", fillDone, 0);
    @(posedge clk);
    #1;
    // fill blocks 0, 2 and 31 with distinct patterns
    for (int i = 0; i < 8; i++) doWrite(i, 32'hA000_0000 + i * 32'h11);
    for (int i = 16; i < 24; i++) doWrite(i, 32'hB100_0000 ^ (i * 32'h0101_0303));
    for (int i = 248; i < 256; i++) doWrite(i, 32'hC0DE_0000 + i);
    // R8 different banks back to back
    doWrite(40, 32'h1);
    acc1 = lastAcc;
    doWrite(41, 32'h2);
    chk(lastAcc == acc1 + 1, "R8 consecutive writes", lastAcc, acc1 + 1);
    // R6 same bank spacing
    doWrite(44, 32'h3);
    acc1 = lastAcc;
    doWrite(48, 32'h4);
    chk(lastAcc == acc1 + 1 + L, "R6 same bank spacing", lastAcc, acc1 + 1 + L);
    // fills
    doFill(0);
    waitDone();
    doFill(31);
    waitDone();
    // write then immediate fill request (R7 wait)
    doWrite(17, 32'hFEED_0017);
    doFill(2);
    waitDone();
    // write issued during a fill waits for its end (R6)
    doFill(31);
    doWrite(250, 32'h5A5A_A5A5);
    doFill(31);
    waitDone();
    // same-bank overwrites then fill of the modified block
    doWrite(16, 32'h0000_1616);
    doWrite(20, 32'h0000_2020);
    doFill(2);
    waitDone();
    repeat (10) @(posedge clk);
    chk(qAt.size() == 0, "R3 all words delivered", qAt.size(), 0);
    finishRun();
  end
endmodule